// File: doc/BRIEF.md
# Host Channel Latency Emulator

This block stands in for a host memory port during accelerator simulation. It takes cache-line read requests and write requests, each with an address and a metadata tag, and answers each one after a pseudo-random delay. Read answers carry the line data and the tag. Write answers are bare acknowledges that carry the tag. Host memory is a small line RAM inside the block. Write data lands in it when the write is accepted. Read data is copied out of it when the read is accepted.

Each accepted request waits in a per-channel pending queue with its own countdown. The countdown starts at a fixed base plus the current cycle count modulo a jitter range. Because of this, a later request can finish before an earlier one. Whenever a register-access request is present, no read answer leaves that cycle. Each channel raises an almost-full flag so the requester can stop issuing before its queue overflows.

Top module: `hostlat_emu`

## Requirements
- R1: A request accepted at the k-th rising edge after reset release (k counted from 0) is answered in the cycle that follows edge k + 8 + (k mod 8). This holds when the answer is not held back by R2 or R4.
- R2: Each cycle, each channel answers the oldest pending request whose countdown has expired. A younger request with a shorter countdown is therefore answered before an older request with a longer one.
- R3: In any cycle, at most one read answer and at most one write acknowledge are valid. Each carries the tag of the request it answers, and every answer corresponds to an earlier accepted request.
- R4: No read answer is valid in the cycle after an edge at which `reg_access_valid` was high. The expired request keeps waiting and is answered at a later edge where `reg_access_valid` is low. Write acknowledges are not affected.
- R5: A channel's almost-full output is high exactly when 15 or more of its 16 queue slots hold pending requests. A request presented while that flag is high is dropped, and the requester must not present one.
- R6: A write's line is stored in the line RAM at the edge that accepts it. A read's data is taken from the RAM at the edge that accepts it. A read accepted at the same edge as a write to the same line returns the line's previous contents. A read accepted after a write to that line returns the new contents.
- R7: The 2-bit type fields of both answer channels are always 0.
- R8: A synchronous reset empties both queues and restarts the cycle count. No answer appears after reset for a request accepted before it, and both almost-full flags are low. The line RAM keeps its contents across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_access_valid | input | 1 | A register read or write is present this cycle; blocks read answers |
| rd_req_valid | input | 1 | Read request present |
| rd_req_addr | input | ADDR_W (4) | Line address of the read |
| rd_req_tag | input | TAG_W (8) | Metadata tag of the read |
| rd_afull | output | 1 | Read queue almost full |
| wr_req_valid | input | 1 | Write request present |
| wr_req_addr | input | ADDR_W (4) | Line address of the write |
| wr_req_tag | input | TAG_W (8) | Metadata tag of the write |
| wr_req_data | input | LINE_W (64) | Line data to store |
| wr_afull | output | 1 | Write queue almost full |
| rd_rsp_valid | output | 1 | Read answer valid |
| rd_rsp_tag | output | TAG_W (8) | Tag of the answered read |
| rd_rsp_data | output | LINE_W (64) | Line data captured at acceptance |
| rd_rsp_type | output | 2 | Read answer type, always 0 |
| wr_ack_valid | output | 1 | Write acknowledge valid |
| wr_ack_tag | output | TAG_W (8) | Tag of the acknowledged write |
| wr_ack_type | output | 2 | Write acknowledge type, always 0 |

## Verification
The hardest state to reach from the ports is a read queue holding 15 pending entries. Every countdown expires after at most 15 cycles, and the queue drains one entry per cycle, so back-to-back issue alone never fills it. The stimulus holds `reg_access_valid` high for the whole fill, which stops every read answer. It keeps issuing reads until the flag rises, then releases the hold and checks that exactly the accepted reads drain, one per cycle and oldest first. Out-of-order completion is reached by issuing one read at a cycle count of 7 mod 8 and the next read at 0 mod 8. The second read's shorter countdown then overtakes the first.

// File: rtl/hostlat_pkg.sv
package hostlat_pkg;

    localparam int RSP_KIND_W = 2;

    typedef enum logic [RSP_KIND_W-1:0] {
        RSP_PLAIN = 2'd0
    } rsp_kind_e;

endpackage

// File: rtl/hostlat_jitter_clock.sv
module hostlat_jitter_clock #(
    parameter int BASE_LAT   = 8,
    parameter int JITTER_MOD = 8,
    parameter int DLY_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    output logic [DLY_W-1:0] delay
);
    localparam int PH_W = (JITTER_MOD > 1) ? $clog2(JITTER_MOD) : 1;

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } jstate_t;

    jstate_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.phase == PH_W'(JITTER_MOD - 1)) begin
            s_d.phase = '0;
        end else begin
            s_d.phase = s_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign delay = DLY_W'(BASE_LAT) + DLY_W'(s_q.phase);

endmodule

// File: rtl/hostlat_line_store.sv
module hostlat_line_store #(
    parameter int ADDR_W = 4,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LINE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [LINE_W-1:0] rd_data
);
    localparam int LINES = 1 << ADDR_W;

    logic [LINE_W-1:0] mem_q [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Combinational read: a same-edge write is not yet visible.
    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/hostlat_oldest_pick.sv
module hostlat_oldest_pick #(
    parameter int N = 16
) (
    input  logic [N-1:0]         ready,
    output logic                 found,
    output logic [$clog2(N)-1:0] index
);
    localparam int IDX_W = $clog2(N);

    always_comb begin
        index = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (ready[i]) begin
                index = IDX_W'(i);
            end
        end
    end

    assign found = |ready;

endmodule

// File: rtl/hostlat_delay_queue.sv
module hostlat_delay_queue #(
    parameter int DEPTH     = 16,
    parameter int PAY_W     = 8,
    parameter int DLY_W     = 4,
    parameter int AFULL_LVL = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_valid,
    input  logic [DLY_W-1:0] push_delay,
    input  logic [PAY_W-1:0] push_payload,
    input  logic             hold,
    output logic             pop_valid,
    output logic [PAY_W-1:0] pop_payload,
    output logic             almost_full
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DLY_W-1:0] left;
        logic [DEPTH-1:0][PAY_W-1:0] pay;
        logic [CNT_W-1:0]            used;
        logic                        out_vld;
        logic [PAY_W-1:0]            out_pay;
    } qstate_t;

    qstate_t s_d, s_q;

    logic [DEPTH-1:0][DLY_W-1:0] dec_left;
    logic [DEPTH-1:0]            ready;
    logic                        found;
    logic [IDX_W-1:0]            pick;
    logic                        pop_now;

    // Slot 0 is the oldest entry; live slots are packed at the low end.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic live;
        assign live        = (CNT_W'(g) < s_q.used);
        assign dec_left[g] = (live && (s_q.left[g] != '0)) ? (s_q.left[g] - 1'b1) : s_q.left[g];
        assign ready[g]    = live && (dec_left[g] == '0);
    end

    hostlat_oldest_pick #(.N(DEPTH)) u_pick (
        .ready (ready),
        .found (found),
        .index (pick)
    );

    assign almost_full = (s_q.used >= CNT_W'(AFULL_LVL));
    assign pop_now     = found && !hold;

    always_comb begin
        s_d         = s_q;
        s_d.left    = dec_left;
        s_d.out_vld = 1'b0;
        s_d.out_pay = '0;

        if (pop_now) begin
            s_d.out_vld = 1'b1;
            s_d.out_pay = s_q.pay[pick];
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= pick) begin
                    s_d.left[i] = dec_left[i + 1];
                    s_d.pay[i]  = s_q.pay[i + 1];
                end
            end
            s_d.left[DEPTH-1] = '0;
            s_d.pay[DEPTH-1]  = '0;
            s_d.used          = s_q.used - 1'b1;
        end

        if (push_valid && !almost_full) begin
            s_d.left[s_d.used[IDX_W-1:0]] = push_delay;
            s_d.pay[s_d.used[IDX_W-1:0]]  = push_payload;
            s_d.used                      = s_d.used + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pop_valid   = s_q.out_vld;
    assign pop_payload = s_q.out_pay;

endmodule

// File: rtl/hostlat_emu.sv
module hostlat_emu #(
    parameter int ADDR_W     = 4,
    parameter int TAG_W      = 8,
    parameter int LINE_W     = 64,
    parameter int DEPTH      = 16,
    parameter int AFULL_LVL  = 15,
    parameter int BASE_LAT   = 8,
    parameter int JITTER_MOD = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               reg_access_valid,
    input  logic                               rd_req_valid,
    input  logic [ADDR_W-1:0]                  rd_req_addr,
    input  logic [TAG_W-1:0]                   rd_req_tag,
    output logic                               rd_afull,
    input  logic                               wr_req_valid,
    input  logic [ADDR_W-1:0]                  wr_req_addr,
    input  logic [TAG_W-1:0]                   wr_req_tag,
    input  logic [LINE_W-1:0]                  wr_req_data,
    output logic                               wr_afull,
    output logic                               rd_rsp_valid,
    output logic [TAG_W-1:0]                   rd_rsp_tag,
    output logic [LINE_W-1:0]                  rd_rsp_data,
    output logic [hostlat_pkg::RSP_KIND_W-1:0] rd_rsp_type,
    output logic                               wr_ack_valid,
    output logic [TAG_W-1:0]                   wr_ack_tag,
    output logic [hostlat_pkg::RSP_KIND_W-1:0] wr_ack_type
);
    import hostlat_pkg::*;

    localparam int DLY_W   = $clog2(BASE_LAT + JITTER_MOD);
    localparam int RD_PAY_W = TAG_W + LINE_W;

    logic [DLY_W-1:0]    delay;
    logic                wr_accept;
    logic [LINE_W-1:0]   line_now;
    logic [RD_PAY_W-1:0] rd_pay_out;

    hostlat_jitter_clock #(
        .BASE_LAT   (BASE_LAT),
        .JITTER_MOD (JITTER_MOD),
        .DLY_W      (DLY_W)
    ) u_jitter (
        .clk   (clk),
        .rst   (rst),
        .delay (delay)
    );

    assign wr_accept = wr_req_valid && !wr_afull;

    hostlat_line_store #(
        .ADDR_W (ADDR_W),
        .LINE_W (LINE_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_accept),
        .wr_addr (wr_req_addr),
        .wr_data (wr_req_data),
        .rd_addr (rd_req_addr),
        .rd_data (line_now)
    );

    hostlat_delay_queue #(
        .DEPTH     (DEPTH),
        .PAY_W     (RD_PAY_W),
        .DLY_W     (DLY_W),
        .AFULL_LVL (AFULL_LVL)
    ) u_rd_queue (
        .clk          (clk),
        .rst          (rst),
        .push_valid   (rd_req_valid),
        .push_delay   (delay),
        .push_payload ({rd_req_tag, line_now}),
        .hold         (reg_access_valid),
        .pop_valid    (rd_rsp_valid),
        .pop_payload  (rd_pay_out),
        .almost_full  (rd_afull)
    );

    hostlat_delay_queue #(
        .DEPTH     (DEPTH),
        .PAY_W     (TAG_W),
        .DLY_W     (DLY_W),
        .AFULL_LVL (AFULL_LVL)
    ) u_wr_queue (
        .clk          (clk),
        .rst          (rst),
        .push_valid   (wr_req_valid),
        .push_delay   (delay),
        .push_payload (wr_req_tag),
        .hold         (1'b0),
        .pop_valid    (wr_ack_valid),
        .pop_payload  (wr_ack_tag),
        .almost_full  (wr_afull)
    );

    assign rd_rsp_tag  = rd_pay_out[RD_PAY_W-1:LINE_W];
    assign rd_rsp_data = rd_pay_out[LINE_W-1:0];
    assign rd_rsp_type = RSP_PLAIN;
    assign wr_ack_type = RSP_PLAIN;

endmodule

// File: rtl/hostlat_emu_chk.sv
module hostlat_emu_chk #(
    parameter int DEPTH     = 16,
    parameter int AFULL_LVL = 15
) (
    input logic clk,
    input logic rst,
    input logic reg_access_valid,
    input logic rd_req_valid,
    input logic rd_afull,
    input logic wr_req_valid,
    input logic wr_afull,
    input logic rd_rsp_valid,
    input logic wr_ack_valid
);
    localparam int OW = $clog2(DEPTH + 1) + 1;

    logic [OW-1:0] rd_open_q;
    logic [OW-1:0] wr_open_q;
    logic          rst_d1_q;

    always_ff @(posedge clk) begin
        rst_d1_q <= rst;
        if (rst) begin
            rd_open_q <= '0;
            wr_open_q <= '0;
        end else begin
            rd_open_q <= rd_open_q + OW'(rd_req_valid && !rd_afull) - OW'(rd_rsp_valid);
            wr_open_q <= wr_open_q + OW'(wr_req_valid && !wr_afull) - OW'(wr_ack_valid);
        end
    end

    AST_RD_HELD: assert property (@(posedge clk) disable iff (rst)
        reg_access_valid |=> !rd_rsp_valid); // R4

    AST_RD_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
        rd_rsp_valid |-> (rd_open_q != '0)); // R3

    AST_WR_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
        wr_ack_valid |-> (wr_open_q != '0)); // R3

    AST_RD_AFULL_LEVEL: assert property (@(posedge clk) disable iff (rst)
        rd_afull == ((rd_open_q - OW'(rd_rsp_valid)) >= OW'(AFULL_LVL))); // R5

    AST_WR_AFULL_LEVEL: assert property (@(posedge clk) disable iff (rst)
        wr_afull == ((wr_open_q - OW'(wr_ack_valid)) >= OW'(AFULL_LVL))); // R5

    AST_NO_RD_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        !(rd_req_valid && rd_afull)); // R5

    AST_NO_WR_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        !(wr_req_valid && wr_afull)); // R5

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        rst_d1_q |-> (!rd_rsp_valid && !wr_ack_valid && !rd_afull && !wr_afull)); // R8

endmodule

bind hostlat_emu hostlat_emu_chk #(
    .DEPTH     (DEPTH),
    .AFULL_LVL (AFULL_LVL)
) i_chk (.*);

// File: tb/test_hostlat_emu.sv
module test_hostlat_emu;

    localparam int AFULL = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_access_valid = 1'b0;
    logic        rd_req_valid = 1'b0;
    logic [3:0]  rd_req_addr = '0;
    logic [7:0]  rd_req_tag = '0;
    logic        rd_afull;
    logic        wr_req_valid = 1'b0;
    logic [3:0]  wr_req_addr = '0;
    logic [7:0]  wr_req_tag = '0;
    logic [63:0] wr_req_data = '0;
    logic        wr_afull;
    logic        rd_rsp_valid;
    logic [7:0]  rd_rsp_tag;
    logic [63:0] rd_rsp_data;
    logic [1:0]  rd_rsp_type;
    logic        wr_ack_valid;
    logic [7:0]  wr_ack_tag;
    logic [1:0]  wr_ack_type;

    always #10 clk = ~clk; // 50 MHz

    hostlat_emu i_hostlat_emu (
        .clk              (clk),
        .rst              (rst),
        .reg_access_valid (reg_access_valid),
        .rd_req_valid     (rd_req_valid),
        .rd_req_addr      (rd_req_addr),
        .rd_req_tag       (rd_req_tag),
        .rd_afull         (rd_afull),
        .wr_req_valid     (wr_req_valid),
        .wr_req_addr      (wr_req_addr),
        .wr_req_tag       (wr_req_tag),
        .wr_req_data      (wr_req_data),
        .wr_afull         (wr_afull),
        .rd_rsp_valid     (rd_rsp_valid),
        .rd_rsp_tag       (rd_rsp_tag),
        .rd_rsp_data      (rd_rsp_data),
        .rd_rsp_type      (rd_rsp_type),
        .wr_ack_valid     (wr_ack_valid),
        .wr_ack_tag       (wr_ack_tag),
        .wr_ack_type      (wr_ack_type)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  waddr;
        logic [7:0]  wtag;
        logic [63:0] wdata;
        logic        rd;
        logic [3:0]  raddr;
        logic [7:0]  rtag;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 4'd0, 8'h10, 64'h1111_0000_aaaa_0000, 1'b0, 4'd0, 8'h00},
        '{1'b1, 4'd1, 8'h11, 64'h1111_0001_aaaa_0001, 1'b0, 4'd0, 8'h00},
        '{1'b1, 4'd2, 8'h12, 64'h1111_0002_aaaa_0002, 1'b0, 4'd0, 8'h00},
        '{1'b1, 4'd3, 8'h13, 64'h1111_0003_aaaa_0003, 1'b0, 4'd0, 8'h00},
        '{1'b1, 4'd4, 8'h14, 64'h1111_0004_aaaa_0004, 1'b0, 4'd0, 8'h00},
        '{1'b1, 4'd5, 8'h15, 64'h1111_0005_aaaa_0005, 1'b0, 4'd0, 8'h00},
        '{1'b1, 4'd6, 8'h16, 64'h1111_0006_aaaa_0006, 1'b0, 4'd0, 8'h00},
        '{1'b1, 4'd7, 8'h17, 64'h1111_0007_aaaa_0007, 1'b0, 4'd0, 8'h00},
        '{1'b0, 4'd0, 8'h00, 64'h0,                   1'b1, 4'd0, 8'h80},
        '{1'b1, 4'd3, 8'h18, 64'h2222_0003_bbbb_0003, 1'b1, 4'd3, 8'h81},
        '{1'b0, 4'd0, 8'h00, 64'h0,                   1'b1, 4'd1, 8'h82},
        '{1'b0, 4'd0, 8'h00, 64'h0,                   1'b1, 4'd2, 8'h83},
        '{1'b0, 4'd0, 8'h00, 64'h0,                   1'b1, 4'd4, 8'h84},
        '{1'b0, 4'd0, 8'h00, 64'h0,                   1'b1, 4'd5, 8'h85},
        '{1'b0, 4'd0, 8'h00, 64'h0,                   1'b1, 4'd3, 8'h86},
        '{1'b0, 4'd0, 8'h00, 64'h0,                   1'b1, 4'd6, 8'h87},
        '{1'b0, 4'd0, 8'h00, 64'h0,                   1'b1, 4'd7, 8'h88}
    };

    int n_checks = 0;
    int n_errs   = 0;
    int e        = 0;

    int          rd_tag [256];
    int          rd_due [256];
    logic [63:0] rd_dat [256];
    bit          rd_live[256];
    int          rd_n = 0;
    int          wr_tag [256];
    int          wr_due [256];
    bit          wr_live[256];
    int          wr_n = 0;
    logic [63:0] mirror [16];
    bit          saw_reorder = 1'b0;
    int          last_rd = -1;
    int          rd_seen = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 256; i++) begin
            rd_live[i] = 1'b0;
            wr_live[i] = 1'b0;
        end
        rd_n = 0;
        wr_n = 0;
        last_rd = -1;
        e = 0;
    endtask

    task automatic idle();
        rd_req_valid     = 1'b0;
        wr_req_valid     = 1'b0;
        reg_access_valid = 1'b0;
    endtask

    // One clock edge: inputs are already set; compare outputs after the edge.
    task automatic tick();
        int  rd_open = 0;
        int  wr_open = 0;
        int  exp_rd  = -1;
        int  exp_wr  = -1;
        bit  hold;
        for (int i = 0; i < rd_n; i++) if (rd_live[i]) rd_open++;
        for (int i = 0; i < wr_n; i++) if (wr_live[i]) wr_open++;
        check(rd_afull == (rd_open >= AFULL), "R5", "rd_afull", 64'(rd_afull), 64'(rd_open >= AFULL));
        check(wr_afull == (wr_open >= AFULL), "R5", "wr_afull", 64'(wr_afull), 64'(wr_open >= AFULL));
        if (rd_req_valid && !rd_afull) begin
            rd_tag[rd_n]  = int'(rd_req_tag);
            rd_dat[rd_n]  = mirror[rd_req_addr];
            rd_due[rd_n]  = e + 8 + (e % 8);
            rd_live[rd_n] = 1'b1;
            rd_n++;
        end
        if (wr_req_valid && !wr_afull) begin
            wr_tag[wr_n]  = int'(wr_req_tag);
            wr_due[wr_n]  = e + 8 + (e % 8);
            wr_live[wr_n] = 1'b1;
            wr_n++;
            mirror[wr_req_addr] = wr_req_data;
        end
        hold = reg_access_valid;
        @(posedge clk);
        @(negedge clk);
        if (!hold) begin
            for (int i = 0; i < rd_n; i++) begin
                if (exp_rd < 0 && rd_live[i] && rd_due[i] <= e) exp_rd = i;
            end
        end
        for (int i = 0; i < wr_n; i++) begin
            if (exp_wr < 0 && wr_live[i] && wr_due[i] <= e) exp_wr = i;
        end
        check(rd_rsp_valid == (exp_rd >= 0), "R1", "rd_rsp_valid", 64'(rd_rsp_valid), 64'(exp_rd >= 0));
        check(wr_ack_valid == (exp_wr >= 0), "R1", "wr_ack_valid", 64'(wr_ack_valid), 64'(exp_wr >= 0));
        if (rd_rsp_valid) rd_seen++;
        if (exp_rd >= 0) begin
            check(int'(rd_rsp_tag) == rd_tag[exp_rd], "R3", "rd_rsp_tag", 64'(rd_rsp_tag), 64'(rd_tag[exp_rd]));
            check(rd_rsp_data == rd_dat[exp_rd], "R6", "rd_rsp_data", rd_rsp_data, rd_dat[exp_rd]);
            rd_live[exp_rd] = 1'b0;
            if (exp_rd < last_rd) saw_reorder = 1'b1;
            last_rd = exp_rd;
        end
        if (exp_wr >= 0) begin
            check(int'(wr_ack_tag) == wr_tag[exp_wr], "R3", "wr_ack_tag", 64'(wr_ack_tag), 64'(wr_tag[exp_wr]));
            wr_live[exp_wr] = 1'b0;
        end
        check(rd_rsp_type == 2'd0 && wr_ack_type == 2'd0, "R7", "type fields",
              64'({rd_rsp_type, wr_ack_type}), 64'd0);
        e++;
    endtask

    task automatic do_reset();
        idle();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        check(!rd_rsp_valid && !wr_ack_valid, "R8", "answers after reset",
              64'({rd_rsp_valid, wr_ack_valid}), 64'd0);
        check(!rd_afull && !wr_afull, "R8", "afull after reset",
              64'({rd_afull, wr_afull}), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        int due;
        int acc;
        do_reset();

        // Vector table: writes, then reads incl. same-line read+write and a reorder pair.
        for (int v = 0; v < NVEC; v++) begin
            wr_req_valid = VECS[v].wr;
            wr_req_addr  = VECS[v].waddr;
            wr_req_tag   = VECS[v].wtag;
            wr_req_data  = VECS[v].wdata;
            rd_req_valid = VECS[v].rd;
            rd_req_addr  = VECS[v].raddr;
            rd_req_tag   = VECS[v].rtag;
            tick();
        end
        idle();
        repeat (24) tick();
        check(saw_reorder, "R2", "younger read overtook older", 64'(saw_reorder), 64'd1);

        // R4: register access blocks a due read answer but not a write ack.
        rd_req_valid = 1'b1; rd_req_addr = 4'd0; rd_req_tag = 8'hC0;
        wr_req_valid = 1'b1; wr_req_addr = 4'd9; wr_req_tag = 8'hC1;
        wr_req_data = 64'h3333_0009_cccc_0009;
        due = e + 8 + (e % 8);
        tick();
        idle();
        while (e < due) tick();
        reg_access_valid = 1'b1;
        tick();
        check(!rd_rsp_valid, "R4", "read held at due edge", 64'(rd_rsp_valid), 64'd0);
        check(wr_ack_valid && wr_ack_tag == 8'hC1, "R4", "write ack not held",
              64'({wr_ack_valid, wr_ack_tag}), 64'({1'b1, 8'hC1}));
        repeat (2) begin
            tick();
            check(!rd_rsp_valid, "R4", "read still held", 64'(rd_rsp_valid), 64'd0);
        end
        reg_access_valid = 1'b0;
        tick();
        check(rd_rsp_valid && rd_rsp_tag == 8'hC0, "R4", "read released",
              64'({rd_rsp_valid, rd_rsp_tag}), 64'({1'b1, 8'hC0}));
        repeat (4) tick();

        // R5: fill the read queue under a continuous hold.
        acc = 0;
        reg_access_valid = 1'b1;
        for (int k = 0; k < 20; k++) begin
            if (!rd_afull) begin
                rd_req_valid = 1'b1;
                rd_req_addr  = 4'(k % 8);
                rd_req_tag   = 8'(8'hD0 + k);
                acc++;
            end else begin
                rd_req_valid = 1'b0;
            end
            tick();
        end
        check(acc == AFULL, "R5", "reads accepted before almost-full", 64'(acc), 64'(AFULL));
        check(rd_afull, "R5", "rd_afull with 15 pending", 64'(rd_afull), 64'd1);
        idle();
        rd_seen = 0;
        repeat (40) tick();
        check(rd_seen == AFULL, "R5", "drained answers", 64'(rd_seen), 64'(AFULL));
        check(!rd_afull, "R5", "rd_afull after drain", 64'(rd_afull), 64'd0);

        // R8: reset with requests pending; nothing may come out afterwards.
        for (int k = 0; k < 3; k++) begin
            rd_req_valid = 1'b1; rd_req_addr = 4'(k); rd_req_tag = 8'(8'hE0 + k);
            wr_req_valid = 1'b1; wr_req_addr = 4'(10 + k); wr_req_tag = 8'(8'hE8 + k);
            wr_req_data  = 64'(k);
            tick();
        end
        do_reset();
        rd_seen = 0;
        repeat (30) tick();
        check(rd_seen == 0, "R8", "no answers for pre-reset reads", 64'(rd_seen), 64'd0);

        // R8: line RAM survives reset; R1 timing from a fresh count.
        rd_req_valid = 1'b1; rd_req_addr = 4'd11; rd_req_tag = 8'hF1;
        tick();
        idle();
        repeat (20) tick();

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule